// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides, for every identifier that arrives at the end of a received frame, whether the frame is kept, which of two receive queues gets it, and which filter accepted it. It holds a bank of `NUM_FILT` filters. Each filter has two 32-bit data words and a small control nibble. Software loads both while the bank lock input is high. The bank is shared by two CAN controllers. A programmable split point gives the low-numbered filters to controller 0 and the rest to controller 1.

Software sets `cfg_lock`, writes the words and control nibbles, writes the split point, and then clears the lock. The receive path presents the 32-bit identifier word, which carries the standard ID at bits 31:21, the extended ID at bits 31:3, IDE at bit 2 and RTR at bit 1. It also presents a controller select and pulses `frame_strobe`. Two clock cycles later the result appears for one cycle, flagged by `res_valid`, and the result outputs hold it until the next lookup.

Top module: `can_accept_filter`

## Requirements
- R1: After synchronous reset every filter is disabled, the split point is `NUM_FILT/2`, and `res_valid`, `res_accept`, `res_fifo` and `res_index` are all 0. A lookup made before any configuration is rejected.
- R2: A configuration write takes effect only when `cfg_lock` is 1 in the cycle `cfg_wr_en` is sampled. With the lock at 0 the write changes nothing. `cfg_kind` selects the target: 0 writes data word A, 1 writes data word B, 2 writes the control nibble, and 3 writes the split point. The control nibble uses `cfg_wdata[0]` for enable, `[1]` for 32-bit scale (0 means 16-bit), `[2]` for list mode (0 means mask mode) and `[3]` for queue 1 (0 means queue 0).
- R3: In 32-bit mask mode, word A is the reference identifier and word B is the mask. A mask bit of 1 requires that identifier bit to be equal, and a mask bit of 0 ignores it. Identifier bit 0 is never compared in any 32-bit mode.
- R4: In 32-bit list mode, the frame matches when bits 31:1 of the identifier equal those of word A or of word B.
- R5: In 16-bit modes, the frame is reduced to a 16-bit key. From bit 15 down, the key is standard ID[10:0], RTR, IDE, and identifier bits 20:18. In mask mode, each word gives a reference in bits 15:0 and its mask in bits 31:16, and a match on either word is enough.
- R6: In 16-bit list mode, the four halves of words A and B are four exact keys, and a key equal to any of them matches.
- R7: A disabled filter never matches. A frame with no matching filter gives `res_accept`=0, `res_fifo`=0 and `res_index`=0.
- R8: When several filters match, the lowest-numbered one is reported.
- R9: `res_fifo` is the queue bit of the reporting filter.
- R10: With split point S, controller 0 (`frame_ctrl`=0) sees only filters 0..S-1 and controller 1 sees only filters S..NUM_FILT-1. A split write outside 1..NUM_FILT-1 is ignored.
- R11: `res_valid` is high exactly two cycles after the cycle in which `frame_strobe` is sampled, for one cycle. The result outputs do not change in other cycles.
- R12: A lookup made while `cfg_lock` is 1 is rejected with `res_accept`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lock | input | 1 | Bank lock; configuration writes allowed while high, lookups rejected |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: word A, word B, control nibble, split point |
| cfg_index | input | IDX_W | Filter number for word and control writes |
| cfg_wdata | input | 32 | Write data |
| frame_strobe | input | 1 | Frame-end pulse starting a lookup |
| frame_ctrl | input | 1 | Controller that received the frame (0 or 1) |
| frame_id | input | 32 | Received identifier word |
| res_valid | output | 1 | One-cycle result flag |
| res_accept | output | 1 | Frame accepted |
| res_fifo | output | 1 | Target receive queue |
| res_index | output | 8 | Number of the accepting filter |

## Verification
Assertions check three things on every cycle. The result pulse comes exactly two cycles after each strobe. Unlocked writes leave the whole bank unchanged, and the split point never leaves its legal range. A disabled filter never produces a registered hit, the reported filter is the lowest of the registered hits, and a locked lookup is never accepted. Only the bench scenarios can show that each of the four compare modes decodes the right fields. Those scenarios also cover the 16-bit key packing of RTR, IDE and the upper extended bits, the queue association, and how moving the split point changes the answer for each controller.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;

    localparam int ACF_WORD_W    = 32;
    localparam int ACF_KEY_W     = 16;
    localparam int ACF_IDX_OUT_W = 8;

    typedef enum logic [1:0] {
        CFG_WORD_A = 2'd0,
        CFG_WORD_B = 2'd1,
        CFG_CTRL   = 2'd2,
        CFG_SPLIT  = 2'd3
    } cfg_kind_e;

    // Control nibble, packed so that write data bits [3:0] cast directly.
    typedef struct packed {
        logic fifo1;  // [3] target queue 1
        logic list;   // [2] list mode
        logic wide;   // [1] 32-bit scale
        logic en;     // [0] enable
    } filt_ctrl_t;

    // 16-bit key: std id, RTR, IDE, top three extended bits.
    function automatic logic [ACF_KEY_W-1:0] short_key(input logic [ACF_WORD_W-1:0] id);
        return {id[31:21], id[1], id[2], id[20:18]};
    endfunction

    // Bit 0 of the identifier word is never compared.
    function automatic logic wide_eq(input logic [ACF_WORD_W-1:0] a,
                                     input logic [ACF_WORD_W-1:0] b,
                                     input logic [ACF_WORD_W-1:0] m);
        return ((a ^ b) & m & 32'hFFFF_FFFE) == '0;
    endfunction

    function automatic logic narrow_eq(input logic [ACF_KEY_W-1:0] a,
                                       input logic [ACF_KEY_W-1:0] b,
                                       input logic [ACF_KEY_W-1:0] m);
        return ((a ^ b) & m) == '0;
    endfunction

    function automatic logic filt_hit(input filt_ctrl_t c,
                                      input logic [ACF_WORD_W-1:0] wa,
                                      input logic [ACF_WORD_W-1:0] wb,
                                      input logic [ACF_WORD_W-1:0] id);
        logic [ACF_KEY_W-1:0] k;
        logic                 r;
        k = short_key(id);
        case ({c.wide, c.list})
            2'b10:   r = wide_eq(id, wa, wb);
            2'b11:   r = wide_eq(id, wa, '1) || wide_eq(id, wb, '1);
            2'b00:   r = narrow_eq(k, wa[15:0], wa[31:16]) || narrow_eq(k, wb[15:0], wb[31:16]);
            default: r = (k == wa[15:0]) || (k == wa[31:16]) || (k == wb[15:0]) || (k == wb[31:16]);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/acf_cfg_regs.sv
module acf_cfg_regs
    import can_acf_pkg::*;
#(
    parameter int NUM_FILT  = 28,
    parameter int IDX_W     = 5,
    parameter int SPLIT_RST = 14
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cfg_lock,
    input  logic                                 cfg_wr_en,
    input  logic [1:0]                           cfg_kind,
    input  logic [IDX_W-1:0]                     cfg_index,
    input  logic [ACF_WORD_W-1:0]                cfg_wdata,
    output logic [NUM_FILT-1:0][ACF_WORD_W-1:0]  word_a,
    output logic [NUM_FILT-1:0][ACF_WORD_W-1:0]  word_b,
    output filt_ctrl_t [NUM_FILT-1:0]            ctrl,
    output logic [IDX_W-1:0]                     split
);

    localparam logic [ACF_WORD_W-1:0] SPLIT_MAX = ACF_WORD_W'(NUM_FILT - 1);

    cfg_kind_e kind;
    logic      idx_ok;
    logic      split_ok;
    logic      wr_go;

    always_comb begin
        kind     = cfg_kind_e'(cfg_kind);
        idx_ok   = int'(cfg_index) < NUM_FILT;
        split_ok = (cfg_wdata != '0) && (cfg_wdata <= SPLIT_MAX);
        wr_go    = cfg_lock && cfg_wr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_a <= '0;
            word_b <= '0;
            ctrl   <= '0;
            split  <= IDX_W'(SPLIT_RST);
        end else if (wr_go) begin
            case (kind)
                CFG_WORD_A: if (idx_ok) word_a[cfg_index] <= cfg_wdata;
                CFG_WORD_B: if (idx_ok) word_b[cfg_index] <= cfg_wdata;
                CFG_CTRL:   if (idx_ok) ctrl[cfg_index]   <= filt_ctrl_t'(cfg_wdata[3:0]);
                default:    if (split_ok) split           <= cfg_wdata[IDX_W-1:0];
            endcase
        end
    end

    // R2: unlocked writes leave the bank untouched
    assert_unlocked_write_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && !cfg_lock) |=> ($stable(word_a) && $stable(word_b) && $stable(ctrl) && $stable(split)));

    // R10: split point stays within 1..NUM_FILT-1
    assert_split_range_R10: assert property (@(posedge clk) disable iff (rst)
        (split != '0) && (int'(split) <= NUM_FILT - 1));

endmodule

// File: rtl/acf_match.sv
module acf_match
    import can_acf_pkg::*;
#(
    parameter int NUM_FILT = 28,
    parameter int IDX_W    = 5
) (
    input  logic [NUM_FILT-1:0][ACF_WORD_W-1:0] word_a,
    input  logic [NUM_FILT-1:0][ACF_WORD_W-1:0] word_b,
    input  filt_ctrl_t [NUM_FILT-1:0]           ctrl,
    input  logic [IDX_W-1:0]                    split,
    input  logic                                frame_ctrl,
    input  logic [ACF_WORD_W-1:0]               frame_id,
    input  logic                                locked,
    output logic [NUM_FILT-1:0]                 hits
);

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
        logic owned;
        always_comb begin
            owned   = frame_ctrl ? (IDX_W'(g) >= split) : (IDX_W'(g) < split);
            hits[g] = ctrl[g].en && !locked && owned &&
                      filt_hit(ctrl[g], word_a[g], word_b[g], frame_id);
        end
    end

endmodule

// File: rtl/acf_pick.sv
module acf_pick
    import can_acf_pkg::*;
#(
    parameter int NUM_FILT = 28,
    parameter int IDX_W    = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [NUM_FILT-1:0]      hits,
    input  logic [NUM_FILT-1:0]      fifo_bits,
    output logic                     res_valid,
    output logic                     res_accept,
    output logic                     res_fifo,
    output logic [ACF_IDX_OUT_W-1:0] res_index
);

    logic             found;
    logic [IDX_W-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_FILT - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_fifo   <= 1'b0;
            res_index  <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_accept <= found;
                res_fifo   <= found && fifo_bits[pick];
                res_index  <= found ? ACF_IDX_OUT_W'(pick) : '0;
            end
        end
    end

    // R8: reported filter is a hit and no lower-numbered hit exists
    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hits != '0) |=>
            (res_accept &&
             ((($past(hits) >> res_index) & NUM_FILT'(1)) == NUM_FILT'(1)) &&
             (($past(hits) & ((NUM_FILT'(1) << res_index) - NUM_FILT'(1))) == '0)));

    // R7: no hit means rejection with zeroed fields
    assert_no_hit_reject_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hits == '0) |=> (!res_accept && !res_fifo && res_index == '0));

    // R11: results hold between lookups
    assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_accept) && $stable(res_fifo) && $stable(res_index)));

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_acf_pkg::*;
#(
    parameter int NUM_FILT = 28,
    parameter int IDX_W    = $clog2(NUM_FILT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_lock,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_kind,
    input  logic [IDX_W-1:0] cfg_index,
    input  logic [31:0]      cfg_wdata,
    input  logic             frame_strobe,
    input  logic             frame_ctrl,
    input  logic [31:0]      frame_id,
    output logic             res_valid,
    output logic             res_accept,
    output logic             res_fifo,
    output logic [7:0]       res_index
);

    localparam int SPLIT_RST = NUM_FILT / 2;

    logic [NUM_FILT-1:0][ACF_WORD_W-1:0] word_a;
    logic [NUM_FILT-1:0][ACF_WORD_W-1:0] word_b;
    filt_ctrl_t [NUM_FILT-1:0]           ctrl;
    logic [IDX_W-1:0]                    split;
    logic [NUM_FILT-1:0]                 hits;
    logic [NUM_FILT-1:0]                 en_vec;
    logic [NUM_FILT-1:0]                 fifo_vec;

    logic                s1_valid;
    logic [NUM_FILT-1:0] s1_hits;
    logic [NUM_FILT-1:0] s1_fifo;

    acf_cfg_regs #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W), .SPLIT_RST(SPLIT_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_lock  (cfg_lock),
        .cfg_wr_en (cfg_wr_en),
        .cfg_kind  (cfg_kind),
        .cfg_index (cfg_index),
        .cfg_wdata (cfg_wdata),
        .word_a    (word_a),
        .word_b    (word_b),
        .ctrl      (ctrl),
        .split     (split)
    );

    acf_match #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_match (
        .word_a     (word_a),
        .word_b     (word_b),
        .ctrl       (ctrl),
        .split      (split),
        .frame_ctrl (frame_ctrl),
        .frame_id   (frame_id),
        .locked     (cfg_lock),
        .hits       (hits)
    );

    always_comb begin
        for (int i = 0; i < NUM_FILT; i++) begin
            en_vec[i]   = ctrl[i].en;
            fifo_vec[i] = ctrl[i].fifo1;
        end
    end

    // Stage 1: capture the per-filter hit vector and queue bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hits  <= '0;
            s1_fifo  <= '0;
        end else begin
            s1_valid <= frame_strobe;
            if (frame_strobe) begin
                s1_hits <= hits;
                s1_fifo <= fifo_vec;
            end
        end
    end

    // Stage 2: priority pick, registered outputs.
    acf_pick #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_pick (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (s1_valid),
        .hits       (s1_hits),
        .fifo_bits  (s1_fifo),
        .res_valid  (res_valid),
        .res_accept (res_accept),
        .res_fifo   (res_fifo),
        .res_index  (res_index)
    );

    // R11: result pulse two cycles after each strobe, and only then
    assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |=> ##1 res_valid);
    assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(frame_strobe, 2));

    // R7: a filter disabled at lookup time never contributes a hit
    assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |=> ((s1_hits & ~$past(en_vec)) == '0));

    // R12: lookups made under the lock are rejected
    assert_locked_reject_R12: assert property (@(posedge clk) disable iff (rst)
        (frame_strobe && cfg_lock) |=> ##1 !res_accept);

endmodule

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_FILT   = 28;
    localparam int IDX_W      = 5;
    localparam int NVEC       = 20;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_lock;
    logic             cfg_wr_en;
    logic [1:0]       cfg_kind;
    logic [IDX_W-1:0] cfg_index;
    logic [31:0]      cfg_wdata;
    logic             frame_strobe;
    logic             frame_ctrl;
    logic [31:0]      frame_id;
    logic             res_valid;
    logic             res_accept;
    logic             res_fifo;
    logic [7:0]       res_index;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_accept_filter #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_can_accept_filter (
        .clk          (clk),
        .rst          (rst),
        .cfg_lock     (cfg_lock),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_kind     (cfg_kind),
        .cfg_index    (cfg_index),
        .cfg_wdata    (cfg_wdata),
        .frame_strobe (frame_strobe),
        .frame_ctrl   (frame_ctrl),
        .frame_id     (frame_id),
        .res_valid    (res_valid),
        .res_accept   (res_accept),
        .res_fifo     (res_fifo),
        .res_index    (res_index)
    );

    // {ctrl, id, accept, fifo, index}
    localparam logic [42:0] VEC [NVEC] = '{
        {1'b0, 32'h2460_0000, 1'b1, 1'b0, 8'd0},   // R3 std 0x123 via filter 0, R8 over filter 5
        {1'b0, 32'h2460_0002, 1'b1, 1'b0, 8'd0},   // R3 RTR masked off
        {1'b0, 32'h2480_0000, 1'b0, 1'b0, 8'd0},   // R7 no filter matches std 0x124
        {1'b0, 32'h0D5E_6F04, 1'b1, 1'b1, 8'd1},   // R4 R9 extended list entry A, queue 1
        {1'b0, 32'h0D5E_6F05, 1'b1, 1'b1, 8'd1},   // R3 R4 bit 0 never compared
        {1'b0, 32'h0AA0_0002, 1'b1, 1'b1, 8'd1},   // R4 list entry B with RTR
        {1'b0, 32'h0AA0_0000, 1'b0, 1'b0, 8'd0},   // R4 list is exact, RTR differs
        {1'b0, 32'h4000_0000, 1'b1, 1'b0, 8'd2},   // R5 16-bit mask, word A
        {1'b0, 32'h4000_0002, 1'b1, 1'b0, 8'd2},   // R5 RTR outside mask
        {1'b0, 32'h60A0_0000, 1'b1, 1'b0, 8'd2},   // R5 word B range 0x300..0x307
        {1'b0, 32'h6100_0000, 1'b0, 1'b0, 8'd0},   // R5 0x308 outside range
        {1'b0, 32'h0200_0000, 1'b1, 1'b1, 8'd3},   // R6 key 1 of 4; R2 unlocked disable ignored
        {1'b0, 32'h0220_0002, 1'b1, 1'b1, 8'd3},   // R6 key 2 (RTR in key)
        {1'b0, 32'h0240_0000, 1'b1, 1'b1, 8'd3},   // R6 key 3
        {1'b0, 32'h0260_0000, 1'b1, 1'b1, 8'd3},   // R6 key 4
        {1'b0, 32'h0260_0002, 1'b0, 1'b0, 8'd0},   // R6 RTR changes key
        {1'b0, 32'h0200_0004, 1'b0, 1'b0, 8'd0},   // R5 IDE bit sits in the key
        {1'b1, 32'h2460_0000, 1'b1, 1'b1, 8'd14},  // R10 controller 1 sees only 14..27
        {1'b1, 32'h0D5E_6F04, 1'b1, 1'b0, 8'd20},  // R10 R9 controller 1 list, queue 0
        {1'b1, 32'h1234_5674, 1'b0, 1'b0, 8'd0}    // R7 controller 1 no match
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] k, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_kind  = k;
        cfg_index = IDX_W'(idx);
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_lock(input logic v);
        @(negedge clk);
        cfg_lock = v;
    endtask

    task automatic lookup(input string req, input logic c, input logic [31:0] id,
                          input logic acc, input logic fifo, input logic [7:0] idx);
        @(negedge clk);
        frame_ctrl   = c;
        frame_id     = id;
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        @(negedge clk);
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check({req, " result"}, 32'({res_accept, res_fifo, res_index}), 32'({acc, fifo, idx}));
    endtask

    task automatic load_filter(input int idx, input logic [3:0] c,
                               input logic [31:0] a, input logic [31:0] b);
        cfg_write(2'd0, idx, a);
        cfg_write(2'd1, idx, b);
        cfg_write(2'd2, idx, 32'(c));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_lock = 1'b0; cfg_wr_en = 1'b0; cfg_kind = '0; cfg_index = '0;
        cfg_wdata = '0; frame_strobe = 1'b0; frame_ctrl = 1'b0; frame_id = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state of outputs
        check("R1 outputs after reset", 32'({res_valid, res_accept, res_fifo, res_index}), 32'd0);
        // R1 no filter enabled after reset
        lookup("R1 lookup before config", 1'b0, 32'h2460_0000, 1'b0, 1'b0, 8'd0);

        set_lock(1'b1);
        // control nibble: [0]en [1]32-bit [2]list [3]queue1
        load_filter(0,  4'b0011, 32'h2460_0000, 32'hFFE0_0000);
        load_filter(1,  4'b1111, 32'h0D5E_6F04, 32'h0AA0_0002);
        load_filter(2,  4'b0001, 32'hFFE0_4000, 32'hFF00_6000);
        load_filter(3,  4'b1101, 32'h0230_0200, 32'h0260_0240);
        load_filter(4,  4'b0010, 32'h0000_0000, 32'h0000_0000);
        load_filter(5,  4'b1011, 32'h2460_0000, 32'hFFE0_0000);
        load_filter(14, 4'b1011, 32'h0000_0000, 32'h0000_0004);
        load_filter(20, 4'b0111, 32'h0D5E_6F04, 32'h0D5E_6F04);
        // R12 locked lookup rejected even though filter 0 matches
        lookup("R12 lookup under lock", 1'b0, 32'h2460_0000, 1'b0, 1'b0, 8'd0);
        set_lock(1'b0);

        // R2 unlocked writes that would disable filter 3 and clear its word
        cfg_write(2'd2, 3, 32'd0);
        cfg_write(2'd0, 3, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            lookup($sformatf("table vector %0d", v), VEC[v][42], VEC[v][41:10],
                   VEC[v][9], VEC[v][8], VEC[v][7:0]);
        end

        // R11 exact pulse timing
        @(negedge clk);
        frame_ctrl = 1'b0; frame_id = 32'h4000_0000; frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        check("R11 valid low one cycle after strobe", 32'(res_valid), 32'd0);
        @(negedge clk);
        check("R11 valid high two cycles after strobe", 32'(res_valid), 32'd1);
        @(negedge clk);
        check("R11 valid drops after one cycle", 32'(res_valid), 32'd0);
        check("R11 result held", 32'({res_accept, res_fifo, res_index}), 32'({1'b1, 1'b0, 8'd2}));

        // R8 disable filter 0, overlapping filter 5 takes over
        set_lock(1'b1);
        cfg_write(2'd2, 0, 32'd0);
        set_lock(1'b0);
        lookup("R8 next-lowest match", 1'b0, 32'h2460_0000, 1'b1, 1'b1, 8'd5);

        // R10 move split to 17
        set_lock(1'b1);
        cfg_write(2'd3, 0, 32'd17);
        // R10 illegal split values ignored
        cfg_write(2'd3, 0, 32'd0);
        cfg_write(2'd3, 0, 32'd28);
        set_lock(1'b0);
        lookup("R10 ctrl1 loses filter 14", 1'b1, 32'h2460_0000, 1'b0, 1'b0, 8'd0);
        lookup("R10 ctrl0 gains filter 14", 1'b0, 32'h2480_0000, 1'b1, 1'b1, 8'd14);
        lookup("R10 ctrl1 keeps filter 20", 1'b1, 32'h0D5E_6F04, 1'b1, 1'b0, 8'd20);

        // R10 boundary split of 1
        set_lock(1'b1);
        cfg_write(2'd3, 0, 32'd1);
        set_lock(1'b0);
        lookup("R10 split 1 ctrl0", 1'b0, 32'h4000_0000, 1'b0, 1'b0, 8'd0);
        lookup("R10 split 1 ctrl1", 1'b1, 32'h4000_0000, 1'b1, 1'b0, 8'd2);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule